// File: doc/BRIEF.md
# Monochrome Text-Mode Video Pixel Generator

This block turns a buffer of character codes into a serial monochrome pixel stream with horizontal and vertical sync, for a screen of 40 columns by 25 rows of 8x8 character cells. A host writes codes into the internal character buffer through a simple write port. While the raster runs, the block reads each code, looks up the matching glyph row in an external font memory and shifts the eight pixels out serially, one pixel every two system clocks.

Two font modes exist. In the primary mode every one of the 256 codes selects its own glyph. In the alternate mode only 128 glyphs are used, and a code with its top bit set shows the glyph of its lower seven bits with every pixel inverted. The mode input is sampled once per frame. A static select picks NTSC-style (262 lines) or PAL-style (312 lines) field timing. Refresh is non-interlaced, so every field is identical, and the 200 active lines are centred vertically.

Top module: `text_pixel_gen`

## Requirements
- R1: The active picture is COLS x ROWS cells of 8x8 pixels; the cell in row r and column c is read from buffer address r*COLS + c, and scanline y of the picture belongs to cell row y/8 and glyph row y%8.
- R2: Each pixel is held on `pix` for exactly two consecutive system clock cycles.
- R3: The font address is {code[7:0], glyph_row[2:0]}, the font memory returns its byte one cycle after the address, and bit 7 of the returned byte is the leftmost pixel of the cell.
- R4: In primary mode (`font_alt` sampled as 0) the full 8-bit code is used as the glyph index and pixels are shown as stored.
- R5: In alternate mode (`font_alt` sampled as 1) the glyph index is {0, code[6:0]}, and when code bit 7 is 1 all eight pixels of the row are inverted.
- R6: `font_alt` is sampled only at the boundary between frames; a change in the middle of a frame has no effect on that frame and applies from the next one.
- R7: With `pal_sel` = 0 a field has LINES_NTSC lines and the first active line is (LINES_NTSC - ROWS*8)/2; with `pal_sel` = 1 a field has LINES_PAL lines and the first active line is (LINES_PAL - ROWS*8)/2.
- R8: `pix` is 0 on every blanking line and outside the horizontal active window of active lines.
- R9: `hsync` is 1 for the first HSYNC_LEN pixel periods of every line and `vsync` is 1 for the first VSYNC_LINES lines of every field; all fields are identical, with no half-line offset.
- R10: Active pixel x of a line is shown in pixel period H_START + x of that line, counting from the rising edge of `hsync`.
- R11: A write with `wr_en` = 1 stores `wr_data` at `wr_addr`; the new code appears the next time that cell is drawn.
- R12: During and right after reset `pix` is 0, `hsync` and `vsync` are 1, the raster starts at pixel 0 of line 0, and the first frame uses primary mode regardless of `font_alt`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (twice the pixel rate) |
| rst_n | input | 1 | Active-low synchronous reset |
| pal_sel | input | 1 | Static field timing select: 0 = 262 lines, 1 = 312 lines |
| font_alt | input | 1 | Font mode request, 1 = alternate mode with inverse video |
| wr_en | input | 1 | Character buffer write enable |
| wr_addr | input | AW | Character buffer write address |
| wr_data | input | 8 | Character code to write |
| font_addr | output | 11 | Font memory address {glyph index, glyph row} |
| font_data | input | 8 | Font memory data, valid one cycle after the address |
| pix | output | 1 | Serial pixel output |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |

## Verification
After reset release every output is a pure function of the count of clock edges: pixel x of line v in frame f is due at edge 2*(f*lines*H_TOTAL + v*H_TOTAL + H_START + x) and stays for that edge and the next, so the bench keeps a count of edges since reset and samples each expected value at the falling clock edge that follows exactly that edge. The internal fetch runs 16 cycles ahead of the cell (buffer read, font address, font data, glyph register), which the bench does not model; it only checks the outputs at the due cycle. A font mode change is checked on lines of the same frame and then of the next frame, and a buffer write made on a blanking line is checked on the active lines of that same frame.

// File: rtl/text_pixel_gen.sv
module text_pixel_gen #(
  parameter int COLS        = 40,
  parameter int ROWS        = 25,
  parameter int H_TOTAL     = 512,
  parameter int H_START     = 104,
  parameter int HSYNC_LEN   = 38,
  parameter int VSYNC_LINES = 3,
  parameter int LINES_NTSC  = 262,
  parameter int LINES_PAL   = 312,
  parameter int AW          = $clog2(COLS * ROWS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pal_sel,
  input  logic          font_alt,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  output logic [10:0]   font_addr,
  input  logic [7:0]    font_data,
  output logic          pix,
  output logic          hsync,
  output logic          vsync
);
  localparam int DEPTH = COLS * ROWS;
  localparam int ACT_W = COLS * 8;
  localparam int ACT_H = ROWS * 8;
  localparam int HW    = $clog2(H_TOTAL + 8);
  localparam int VMAX  = (LINES_PAL > LINES_NTSC) ? LINES_PAL : LINES_NTSC;
  localparam int VW    = $clog2(VMAX);
  localparam int VS_N  = (LINES_NTSC - ACT_H) / 2;
  localparam int VS_P  = (LINES_PAL - ACT_H) / 2;

  logic          ph;
  logic [HW-1:0] hcnt, hf, hrel;
  logic [VW-1:0] vcnt, vrel, v_start, v_last;
  logic          h_end, f_end, v_in, h_in, fetch_go;
  logic [AW-1:0] rd_addr;
  logic [7:0]    mem [DEPTH];
  logic [7:0]    code_q, glyph_q, shreg;
  logic          s1, s2, s3, gv, inv_q, alt_q;

  assign v_last   = pal_sel ? VW'(LINES_PAL - 1) : VW'(LINES_NTSC - 1);
  assign v_start  = pal_sel ? VW'(VS_P) : VW'(VS_N);
  assign vrel     = vcnt - v_start;
  assign v_in     = (vcnt >= v_start) && (vrel < VW'(ACT_H));
  assign hf       = hcnt + HW'(8);
  assign hrel     = hf - HW'(H_START);
  assign h_in     = (hcnt >= HW'(H_START)) && (hcnt < HW'(H_START + ACT_W));
  assign fetch_go = !ph && (hcnt[2:0] == 3'd0) && v_in &&
                    (hf >= HW'(H_START)) && (hrel < HW'(ACT_W));
  assign h_end    = ph && (hcnt == HW'(H_TOTAL - 1));
  assign f_end    = h_end && (vcnt == v_last);
  assign rd_addr  = AW'(32'(vrel[VW-1:3]) * COLS + 32'(hrel[HW-1:3]));

  assign pix   = shreg[7];
  assign hsync = hcnt < HW'(HSYNC_LEN);
  assign vsync = vcnt < VW'(VSYNC_LINES);

  always_ff @(posedge clk) begin
    if (wr_en && (32'(wr_addr) < DEPTH)) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (fetch_go) code_q <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph        <= 1'b0;
      hcnt      <= '0;
      vcnt      <= '0;
      alt_q     <= 1'b0;
      s1        <= 1'b0;
      s2        <= 1'b0;
      s3        <= 1'b0;
      gv        <= 1'b0;
      inv_q     <= 1'b0;
      font_addr <= '0;
      glyph_q   <= '0;
      shreg     <= '0;
    end else begin
      ph <= !ph;
      if (ph) hcnt <= h_end ? '0 : hcnt + HW'(1);
      if (h_end) vcnt <= f_end ? '0 : vcnt + VW'(1);
      if (f_end) alt_q <= font_alt;
      s1 <= fetch_go;
      s2 <= s1;
      s3 <= s2;
      if (s1) begin
        font_addr <= {alt_q ? {1'b0, code_q[6:0]} : code_q, vrel[2:0]};
        inv_q     <= alt_q & code_q[7];
      end
      if (s3) begin
        glyph_q <= font_data ^ {8{inv_q}};
        gv      <= 1'b1;
      end
      if (ph && (hcnt[2:0] == 3'd7)) begin
        shreg <= gv ? glyph_q : 8'h00;
        gv    <= 1'b0;
      end else if (ph) begin
        shreg <= {shreg[6:0], 1'b0};
      end
    end
  end

  assert_pixel_rate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ph |=> $stable(shreg));
  assert_alt_index_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (s2 && alt_q) |-> !font_addr[10]);
  assert_mode_at_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(alt_q) |-> (hcnt == '0 && vcnt == '0 && !ph));
  assert_line_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    h_end |-> (vcnt <= v_last));
  assert_blank_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(h_in && v_in) |-> !pix);
  assert_vsync_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vsync) |-> (hcnt == '0 && !ph));
endmodule

// File: tb/test_text_pixel_gen.sv
module test_text_pixel_gen;
  localparam int CLK_PERIOD = 10;
  localparam int NCOL = 40;
  localparam int NROW = 3;
  localparam int HT   = 400;
  localparam int HS   = 48;
  localparam int HSL  = 32;
  localparam int VSL  = 3;
  localparam int LN   = 30;
  localparam int LP   = 36;
  localparam int NCELL = NCOL * NROW;
  localparam int AWB  = $clog2(NCELL);
  localparam int FTN  = LN * HT * 2;
  localparam int FTP  = LP * HT * 2;
  localparam int VSN  = (LN - NROW * 8) / 2;
  localparam int VSP  = (LP - NROW * 8) / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pal_sel = 1'b0, font_alt = 1'b0, wr_en = 1'b0;
  logic [AWB-1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [10:0] font_addr;
  logic [7:0] font_data;
  logic pix, hsync, vsync;
  int cyc = 0;
  int errs = 0;
  int checks = 0;
  logic [7:0] shadow [NCELL];

  always #(CLK_PERIOD / 2) clk = ~clk;

  text_pixel_gen #(
    .COLS(NCOL), .ROWS(NROW), .H_TOTAL(HT), .H_START(HS), .HSYNC_LEN(HSL),
    .VSYNC_LINES(VSL), .LINES_NTSC(LN), .LINES_PAL(LP), .AW(AWB)
  ) i_text_pixel_gen (
    .clk(clk), .rst_n(rst_n), .pal_sel(pal_sel), .font_alt(font_alt),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .font_addr(font_addr), .font_data(font_data),
    .pix(pix), .hsync(hsync), .vsync(vsync)
  );

  function automatic logic [7:0] glyph_of(input logic [10:0] a);
    return a[10:3] ^ {a[2:0], a[2:0], a[1:0]} ^ 8'h5A;
  endfunction

  always @(posedge clk) font_data <= glyph_of(font_addr);
  always @(posedge clk) if (!rst_n) cyc <= 0; else cyc <= cyc + 1;

  function automatic logic exp_pix(input int v, input int h, input logic alt, input logic pal);
    int vs = pal ? VSP : VSN;
    int x, y;
    logic [7:0] c, g, a;
    if (v < vs || v >= vs + NROW * 8 || h < HS || h >= HS + NCOL * 8) return 1'b0;
    x = h - HS;
    y = v - vs;
    c = shadow[(y / 8) * NCOL + x / 8];
    a = alt ? {1'b0, c[6:0]} : c;
    g = glyph_of({a, 3'(y % 8)});
    if (alt && c[7]) g = ~g;
    return g[7 - (x % 8)];
  endfunction

  task automatic wait_to(input int k);
    while (cyc < k) @(negedge clk);
  endtask

  task automatic write_cell(input int addr, input logic [7:0] code);
    wr_en = 1'b1; wr_addr = AWB'(addr); wr_data = code;
    @(negedge clk);
    wr_en = 1'b0;
    shadow[addr] = code;
  endtask

  task automatic check_line(input int fbase, input int v, input logic alt,
                            input logic pal, input string tag);
    int bad = 0, bs = 0, fh = -1;
    logic fg = 1'b0, fe = 1'b0, e;
    for (int h = 0; h < HT; h++) begin
      for (int p = 0; p < 2; p++) begin
        wait_to(fbase + (v * HT + h) * 2 + p);
        e = exp_pix(v, h, alt, pal);
        if (cyc != fbase + (v * HT + h) * 2 + p || pix !== e) begin
          if (bad == 0) begin fh = h; fg = pix; fe = e; end
          bad++;
        end
        if (hsync !== (h < HSL) || vsync !== (v < VSL)) bs++;
      end
    end
    checks++;
    if (bad != 0) begin
      errs++;
      $display("FAIL %s line %0d pixel %0d: pix=%b expected %b (%0d bad samples)",
               tag, v, fh, fg, fe, bad);
    end
    checks++;
    if (bs != 0) begin
      errs++;
      $display("FAIL R9 line %0d: sync mismatches=%0d expected 0", v, bs);
    end
  endtask

  task automatic do_reset(input logic pal, input logic alt);
    @(negedge clk);
    rst_n = 1'b0; pal_sel = pal; font_alt = alt;
    repeat (3) @(negedge clk);
  endtask

  task automatic check_reset_state();
    checks++;
    if (pix !== 1'b0) begin errs++; $display("FAIL R12 reset pix=%b expected 0", pix); end
    checks++;
    if (hsync !== 1'b1) begin errs++; $display("FAIL R12 reset hsync=%b expected 1", hsync); end
    checks++;
    if (vsync !== 1'b1) begin errs++; $display("FAIL R12 reset vsync=%b expected 1", vsync); end
  endtask

  task automatic t_reset_and_load();
    do_reset(1'b0, 1'b0);
    check_reset_state();
    for (int i = 0; i < NCELL; i++) write_cell(i, 8'(i * 37 + 11));
    rst_n = 1'b1;
  endtask

  task automatic t_primary_frame();
    check_line(0, 0, 1'b0, 1'b0, "R8");
    check_line(0, 2, 1'b0, 1'b0, "R8");
    for (int v = VSN; v < VSN + NROW * 8; v++)
      check_line(0, v, 1'b0, 1'b0, "R1 R3 R4 R10");
    check_line(0, VSN + NROW * 8, 1'b0, 1'b0, "R8");
    check_line(0, LN - 1, 1'b0, 1'b0, "R8");
  endtask

  task automatic t_mode_switch_and_write();
    wait_to(FTN + 9 * HT * 2);
    font_alt = 1'b1;
    check_line(FTN, 10, 1'b0, 1'b0, "R6");
    check_line(FTN, 20, 1'b0, 1'b0, "R6");
    wait_to(2 * FTN + HT * 2);
    write_cell(5, 8'hC1);
    write_cell(NCOL + 1, 8'h03);
    for (int v = VSN; v < VSN + 16; v++)
      check_line(2 * FTN, v, 1'b1, 1'b0, "R5 R11");
    check_line(2 * FTN, LN - 1, 1'b1, 1'b0, "R7");
  endtask

  task automatic t_pal_timing();
    do_reset(1'b1, 1'b1);
    check_reset_state();
    rst_n = 1'b1;
    check_line(0, VSP - 1, 1'b0, 1'b1, "R7 R8");
    check_line(0, VSP, 1'b0, 1'b1, "R7 R12");
    check_line(0, VSP + 1, 1'b0, 1'b1, "R7 R12");
    check_line(FTP, VSP, 1'b1, 1'b1, "R6 R7");
    check_line(FTP, LN - 1, 1'b1, 1'b1, "R7");
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    errs++;
    $display("FAIL R1 watchdog: run not finished, cycle=%0d expected end", cyc);
    $display("Result: errors=%0d of %0d checks", errs, checks + 1);
    $finish;
  end

  initial begin
    t_reset_and_load();
    t_primary_frame();
    t_mode_switch_and_write();
    t_pal_timing();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule